// File: doc/BRIEF.md
# Eight-Bit Carry Lookahead Add Slice

This block adds two 8-bit operands the way a column of six-input lookup elements with a shared lookahead stage would. Every bit position forms its own propagate, generate and sum. The even positions also hold the carry-select mux. A separate lookahead stage then produces a fast carry after each bit pair, that is after bits 1, 3, 5 and 7. Each of the four lookahead outputs has its own enable parameter. When an output is disabled, the carry after that pair comes from the plain ripple mux instead. The arithmetic result is the same either way; only the modelled path changes.

A carry chain starts at bit 0. It can optionally start again at bit 4, which splits the slice into two independent 4-bit adders. At each start point an initialisation mux picks the carry into that bit. By default it takes an external input; it can also be set to drive a constant 1. The sum and the four pair carries are captured in output registers, so a result appears one clock after its operands.

Top module: `cla8_slice`

## Requirements
- R1: With the bit-4 restart off, `sum_q` equals bits 7..0 of `op_a + op_b + c0`. Here c0 is 1 when `init1_lo` is 1, and `cin_lo` otherwise.
- R2: With the bit-4 restart off, `cy_q[k]` (k = 0..3) equals the carry out of the low 2k+2 bits of `op_a + op_b + c0`. Bit k of `cy_q` is the carry after bit 2k+1.
- R3: For every setting of the `LOOK_EN` parameter bits, the sum and all four carries are identical.
- R4: With `split_hi` = 1, `sum_q[7:4]` and `cy_q[3:2]` equal an independent 4-bit add of `op_a[7:4]`, `op_b[7:4]` and c4. Here c4 is 1 when `init1_hi` is 1, and `cin_hi` otherwise. The lower nibble result (`sum_q[3:0]`, `cy_q[1:0]`) follows its own add with c0.
- R5: At each start point the initialisation carry is the external input (`cin_lo` for bit 0, `cin_hi` for bit 4) while the matching force bit is 0. It is a constant 1 when the force bit is 1, whatever the external input.
- R6: With `split_hi` = 0, `cin_hi` and `init1_hi` have no effect on `sum_q` or `cy_q`.
- R7: `sum_q` and `cy_q` update on the rising clock edge one cycle after the inputs are applied. A low `rst_n` sampled on a rising edge clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| cin_lo | input | 1 | External initialisation carry for the chain at bit 0 |
| cin_hi | input | 1 | External initialisation carry for the chain at bit 4 |
| split_hi | input | 1 | 1 restarts the carry chain at bit 4 |
| init1_lo | input | 1 | 1 forces the bit-0 initialisation carry to 1 |
| init1_hi | input | 1 | 1 forces the bit-4 initialisation carry to 1 |
| sum_q | output | 8 | Registered sum |
| cy_q | output | 4 | Registered carries after bits 1, 3, 5 and 7 (bit 0 = after bit 1) |

## Verification
Every result is due exactly one rising edge after its operands and configuration are applied, since the only register on the path is the output stage. The driver changes inputs on the falling edge and pushes the expected sum and carries into a queue. The monitor pops one item a short delay after each rising edge, which is the point where that edge has loaded the result. Three instances with all, none and alternate lookahead outputs enabled are compared against the same expected item in that cycle. This covers every operand pair with both carry-in values, split-chain patterns, and forced-one initialisation.

// File: rtl/cla8_pkg.sv
// Package: shared defaults and the initialisation-source encoding for the
// carry lookahead add slice. Assumes nothing beyond IEEE 1800-2017.
package cla8_pkg;

    // Default slice geometry.
    localparam int unsigned CLA_WIDTH_DEF = 8;
    localparam int unsigned CLA_SPLIT_DEF = 4;

    // Where a chain start point takes its carry from.
    typedef enum logic {
        INIT_EXTERNAL = 1'b0,
        INIT_FORCE_ONE = 1'b1
    } init_src_e;

endpackage : cla8_pkg

// File: rtl/cla_bit_cell.sv
// Module: one bit position of the add slice, shaped like a six-input
// lookup element in carry mode. It forms propagate (XOR of the operand
// bits), generate and sum (propagate XOR incoming carry). With CARRY_MUX
// set (even positions), the main output is the carry-select result
// (incoming carry when propagate is 1, generate otherwise). Without it
// (odd positions), the main output is the generate term, which the
// lookahead stage consumes. Assumes the incoming carry is already selected.
module cla_bit_cell #(
    parameter bit CARRY_MUX = 1'b1
) (
    input  logic a_i,
    input  logic b_i,
    input  logic cin_i,
    output logic prop_o,
    output logic main_o,
    output logic sum_o
);

    logic gen_w;

    // Propagate, generate and sum of this bit position.
    always_comb begin
        prop_o = a_i ^ b_i;
        gen_w  = a_i & b_i;
        sum_o  = prop_o ^ cin_i;
    end

    generate
        if (CARRY_MUX) begin : g_select
            // Carry-select mux held inside the even element.
            always_comb main_o = prop_o ? cin_i : gen_w;
        end else begin : g_plain
            // Odd element presents its generate term for the lookahead mux.
            always_comb main_o = gen_w;
        end
    endgenerate

endmodule : cla_bit_cell

// File: rtl/cla_init_mux.sv
// Module: carry-initialisation mux at a chain start point. When restart_i
// is 1 the carry into the bit is the initialisation value: the external
// input, or a constant 1 when force_one_i is set. Otherwise the chained
// carry from below passes through. Assumes static configuration inputs.
module cla_init_mux
    import cla8_pkg::*;
(
    input  logic chain_i,
    input  logic ext_i,
    input  logic restart_i,
    input  logic force_one_i,
    output logic cin_o
);

    init_src_e src;

    // Choose between the chained carry and the initialisation source.
    always_comb begin
        src = force_one_i ? INIT_FORCE_ONE : INIT_EXTERNAL;
        if (!restart_i)
            cin_o = chain_i;
        else if (src == INIT_FORCE_ONE)
            cin_o = 1'b1;
        else
            cin_o = ext_i;
    end

endmodule : cla_init_mux

// File: rtl/cla_pair_lookahead.sv
// Module: lookahead mux for one bit pair. It produces the carry after the
// odd bit. With LOOK_EN set, a pair whose two bits both propagate takes
// the carry into the pair directly, skipping the even carry-select mux.
// Otherwise the ripple mux is used: the even carry when the odd bit
// propagates, the odd generate term otherwise. Both paths must agree.
module cla_pair_lookahead #(
    parameter bit LOOK_EN = 1'b1
) (
    input  logic cin_pair_i,
    input  logic p_even_i,
    input  logic p_odd_i,
    input  logic cy_even_i,
    input  logic cy_odd_i,
    output logic cout_o
);

    logic ripple_w;
    logic fast_w;

    // Form the ripple and the lookahead carry and check they agree.
    always_comb begin
        ripple_w = p_odd_i ? cy_even_i : cy_odd_i;
        if (p_odd_i && p_even_i)
            fast_w = cin_pair_i;
        else if (p_odd_i)
            fast_w = cy_even_i;
        else
            fast_w = cy_odd_i;
        p_path_equiv_r3: assert (ripple_w == fast_w)
            else $error("lookahead and ripple carry disagree");
    end

    generate
        if (LOOK_EN) begin : g_fast
            // Enabled output drives the lookahead carry.
            always_comb cout_o = fast_w;
        end else begin : g_ripple
            // Disabled output falls back to the ripple mux.
            always_comb cout_o = ripple_w;
        end
    endgenerate

endmodule : cla_pair_lookahead

// File: rtl/cla8_slice.sv
// Module: top of the carry lookahead add slice. WIDTH bit cells are grouped
// into pairs. Each pair has one lookahead mux that produces the carry after
// its odd bit. The chain starts at bit 0 and can restart at SPLIT_BIT. Sum
// and pair carries are registered with a synchronous active-low reset.
// Assumes WIDTH and SPLIT_BIT are even and SPLIT_BIT < WIDTH.
module cla8_slice
    import cla8_pkg::*;
#(
    parameter int unsigned WIDTH     = CLA_WIDTH_DEF,
    parameter int unsigned SPLIT_BIT = CLA_SPLIT_DEF,
    parameter logic [WIDTH/2-1:0] LOOK_EN = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic               cin_lo,
    input  logic               cin_hi,
    input  logic               split_hi,
    input  logic               init1_lo,
    input  logic               init1_hi,
    output logic [WIDTH-1:0]   sum_q,
    output logic [WIDTH/2-1:0] cy_q
);

    localparam int unsigned PAIRS      = WIDTH / 2;
    localparam int unsigned SPLIT_PAIR = SPLIT_BIT / 2;
    localparam int unsigned HI_W       = WIDTH - SPLIT_BIT;

    logic [PAIRS-1:0] pair_cin;
    logic [PAIRS-1:0] pair_cout;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH-1:0] main_w;
    logic [WIDTH-1:0] sum_w;

    genvar k;
    generate
        for (k = 0; k < PAIRS; k++) begin : g_pair
            if (k == 0) begin : g_start
                // Bit 0 always starts a chain.
                cla_init_mux u_init (
                    .chain_i    (1'b0),
                    .ext_i      (cin_lo),
                    .restart_i  (1'b1),
                    .force_one_i(init1_lo),
                    .cin_o      (pair_cin[k])
                );
            end else if (k == SPLIT_PAIR) begin : g_restart
                // Optional second chain start point.
                cla_init_mux u_init (
                    .chain_i    (pair_cout[k-1]),
                    .ext_i      (cin_hi),
                    .restart_i  (split_hi),
                    .force_one_i(init1_hi),
                    .cin_o      (pair_cin[k])
                );
            end else begin : g_chain
                // Plain chaining from the pair below.
                always_comb pair_cin[k] = pair_cout[k-1];
            end

            cla_bit_cell #(.CARRY_MUX(1'b1)) u_even (
                .a_i   (op_a[2*k]),
                .b_i   (op_b[2*k]),
                .cin_i (pair_cin[k]),
                .prop_o(prop_w[2*k]),
                .main_o(main_w[2*k]),
                .sum_o (sum_w[2*k])
            );

            cla_bit_cell #(.CARRY_MUX(1'b0)) u_odd (
                .a_i   (op_a[2*k+1]),
                .b_i   (op_b[2*k+1]),
                .cin_i (main_w[2*k]),
                .prop_o(prop_w[2*k+1]),
                .main_o(main_w[2*k+1]),
                .sum_o (sum_w[2*k+1])
            );

            cla_pair_lookahead #(.LOOK_EN(LOOK_EN[k])) u_look (
                .cin_pair_i(pair_cin[k]),
                .p_even_i  (prop_w[2*k]),
                .p_odd_i   (prop_w[2*k+1]),
                .cy_even_i (main_w[2*k]),
                .cy_odd_i  (main_w[2*k+1]),
                .cout_o    (pair_cout[k])
            );
        end
    endgenerate

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cy_q  <= '0;
        end else begin
            sum_q <= sum_w;
            cy_q  <= pair_cout;
        end
    end

    // Arithmetic references for the clocked properties.
    logic          ref_c0;
    logic          ref_c4;
    logic [WIDTH:0] ref_full;
    logic [HI_W:0]  ref_hi;

    always_comb begin
        ref_c0   = init1_lo | cin_lo;
        ref_c4   = init1_hi | cin_hi;
        ref_full = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, ref_c0};
        ref_hi   = {1'b0, op_a[WIDTH-1:SPLIT_BIT]} + {1'b0, op_b[WIDTH-1:SPLIT_BIT]}
                   + {{HI_W{1'b0}}, ref_c4};
    end

    p_full_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !split_hi |=> (sum_q == $past(ref_full[WIDTH-1:0])));

    p_top_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !split_hi |=> (cy_q[PAIRS-1] == $past(ref_full[WIDTH])));

    p_upper_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        split_hi |=> ({cy_q[PAIRS-1], sum_q[WIDTH-1:SPLIT_BIT]} == $past(ref_hi)));

    p_force_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (split_hi && init1_hi && op_a[WIDTH-1:SPLIT_BIT] == '0 && op_b[WIDTH-1:SPLIT_BIT] == '0)
        |=> (sum_q[WIDTH-1:SPLIT_BIT] == {{(HI_W-1){1'b0}}, 1'b1}));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0 && cy_q == '0));

endmodule : cla8_slice

// File: tb/cla8_slice_tb.sv
// Bench: scoreboard for the add slice. A driver task applies stimulus on
// the falling edge and queues the expected result. A monitor pops and
// compares it one rising edge later on three lookahead variants.
module cla8_slice_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0;
    logic       cin_lo = 1'b0, cin_hi = 1'b0, split_hi = 1'b0;
    logic       init1_lo = 1'b0, init1_hi = 1'b0;
    logic [7:0] sum_f, sum_r, sum_m;
    logic [3:0] cy_f, cy_r, cy_m;

    int checks = 0;
    int fails  = 0;
    logic [11:0] expq[$];
    int          tagq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cla8_slice #(.LOOK_EN(4'b1111)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .cin_lo(cin_lo), .cin_hi(cin_hi), .split_hi(split_hi),
        .init1_lo(init1_lo), .init1_hi(init1_hi), .sum_q(sum_f), .cy_q(cy_f));

    cla8_slice #(.LOOK_EN(4'b0000)) u_ripple (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .cin_lo(cin_lo), .cin_hi(cin_hi), .split_hi(split_hi),
        .init1_lo(init1_lo), .init1_hi(init1_hi), .sum_q(sum_r), .cy_q(cy_r));

    cla8_slice #(.LOOK_EN(4'b0101)) u_mixed (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .cin_lo(cin_lo), .cin_hi(cin_hi), .split_hi(split_hi),
        .init1_lo(init1_lo), .init1_hi(init1_hi), .sum_q(sum_m), .cy_q(cy_m));

    // Reference model built from the requirements: {carries, sum}.
    function automatic logic [11:0] model(input logic [7:0] a, input logic [7:0] b,
                                          input logic cl, input logic ch, input logic sp,
                                          input logic il, input logic ih);
        int c0, c4, s, t, m, lo, hi;
        logic [3:0] cy;
        logic [7:0] sm;
        c0 = il ? 1 : int'(cl);
        c4 = ih ? 1 : int'(ch);
        if (!sp) begin
            s  = int'(a) + int'(b) + c0;
            sm = s[7:0];
            for (int k = 0; k < 4; k++) begin
                m = (1 << (2*k+2)) - 1;
                t = (int'(a) & m) + (int'(b) & m) + c0;
                cy[k] = t[2*k+2];
            end
        end else begin
            lo = (int'(a) & 15) + (int'(b) & 15) + c0;
            hi = (int'(a) >> 4) + (int'(b) >> 4) + c4;
            sm = {hi[3:0], lo[3:0]};
            t  = (int'(a) & 3) + (int'(b) & 3) + c0;
            cy[0] = t[2];
            cy[1] = lo[4];
            t  = ((int'(a) >> 4) & 3) + ((int'(b) >> 4) & 3) + c4;
            cy[2] = t[2];
            cy[3] = hi[4];
        end
        return {cy, sm};
    endfunction

    function automatic string tag_name(input int tag);
        case (tag)
            0: return "R1 R2 R6 R7";
            1: return "R4 R5 R7";
            default: return "R5 R1 R2";
        endcase
    endfunction

    // Driver: apply one vector on the falling edge and queue its result.
    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic cl,
                         input logic ch, input logic sp, input logic il,
                         input logic ih, input int tag);
        @(negedge clk);
        op_a = a; op_b = b; cin_lo = cl; cin_hi = ch;
        split_hi = sp; init1_lo = il; init1_hi = ih;
        expq.push_back(model(a, b, cl, ch, sp, il, ih));
        tagq.push_back(tag);
    endtask

    task automatic check_one(input string who, input string req,
                             input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s a=%h b=%h got %h exp %h", req, who, op_a, op_b, got, exp);
        end
    endtask

    // Monitor: one rising edge after a vector, compare all instances.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                logic [11:0] e;
                int tg;
                e  = expq.pop_front();
                tg = tagq.pop_front();
                check_one("u_dut", tag_name(tg), {cy_f, sum_f}, e);
                check_one("u_ripple", "R3", {cy_r, sum_r}, e);
                check_one("u_mixed", "R3", {cy_m, sum_m}, e);
            end
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired got running exp done");
        finish_run();
    end

    initial begin
        // R7: outputs clear under reset even with busy inputs.
        @(negedge clk);
        op_a = 8'hFF; op_b = 8'h01; cin_lo = 1'b1; init1_lo = 1'b1;
        repeat (3) @(negedge clk);
        check_one("u_dut", "R7 reset", {cy_f, sum_f}, 12'h000);
        check_one("u_ripple", "R7 reset", {cy_r, sum_r}, 12'h000);
        rst_n = 1'b1;
        init1_lo = 1'b0;

        // R1 R2 R6: exhaustive single chain; upper init inputs toggle freely.
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 2; c++)
                    drive(8'(a), 8'(b), c[0], a[5] ^ b[3], 1'b0, 1'b0, a[0], 0);

        // R4 R5: restart at bit 4 with mixed init sources.
        for (int i = 0; i < 4096; i++)
            drive(8'(i), 8'((i >> 4) * 37 + i), i[4], i[5], 1'b1, i[6] & i[8], i[7], 1);

        // R5: force-one at bit 0 overrides a zero external carry.
        for (int i = 0; i < 512; i++)
            drive(8'(i * 13), 8'(i * 7 + 3), i[0], i[1], 1'b0, 1'b1, i[2], 2);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule : cla8_slice_tb